// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a small 32-bit processor core that completes one instruction on every rising clock edge. It holds the program counter and a general-purpose register file. It decodes the instruction presented on its instruction-memory port, computes the result and the next program counter in combinational logic, and commits every state change together at the end of the cycle. It has no pipeline registers, and nothing changes part way through an instruction.

Both memories sit outside the core. The instruction port gives a byte address and expects the 32-bit word back in the same cycle. The data port gives a byte address, write data and a write strobe, and expects load data combinationally. The core supports register-register arithmetic and logic, add-immediate, word load and store, four conditional branches and an absolute jump. Any encoding outside that set retires as a no-op.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0 and dmem_we_o is 0. Reset clears every register.
- R2: Register 0 always reads as zero. A write that targets register 0 is discarded.
- R3: Opcode 0 selects a register operation. The source operands are taken from bits 25:21 and 20:16, the destination is bits 15:11, and bits 10:6 must be zero. The operation is chosen by bits 5:0: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x2A signed set-less-than (result 1 or 0).
- R4: Opcode 0x08 writes register[20:16] with register[25:21] plus the sign-extended bits 15:0.
- R5: Opcode 0x23 loads dmem_rdata_i into register[20:16]. The address is register[25:21] plus the sign-extended offset.
- R6: Opcode 0x2B drives register[20:16] onto dmem_wdata_o at the same address rule and raises dmem_we_o for that cycle. No other opcode raises dmem_we_o.
- R7: Branches compare signed operands: 0x04 taken if equal, 0x05 taken if not equal, 0x06 taken if register[25:21] is at most zero, 0x07 taken if it is above zero. A taken branch goes to PC+4 plus the sign-extended offset times 4. A branch that is not taken goes to PC+4. There is no delay slot.
- R8: Opcode 0x02 jumps to {PC[31:28], bits 25:0, 2'b00}.
- R9: An undefined opcode, or a register operation with an undefined bits 5:0 code or nonzero bits 10:6, changes no register and no memory, and advances the PC by 4.
- R10: Each clock retires exactly one instruction. A non-control instruction advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state commits on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_addr_o | output | 32 | Byte address of the current instruction (the PC) |
| imem_data_i | input | 32 | Instruction word at imem_addr_o, same cycle |
| dmem_addr_o | output | 32 | Data byte address (base plus offset) |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store strobe, one cycle per store |
| dmem_rdata_i | input | 32 | Load data at dmem_addr_o, same cycle |

## Verification
The bench builds the core with its defaults: 32 registers and a reset PC of 0. With these values every encoding in the register fields is legal, and register 0 can be named as a destination and as a store source. The jump target stays inside the first 256 bytes, so the upper PC bits are zero. The bench program uses signed immediates of both signs, one backward branch loop, a branch on register 0 and a jump over dead code. It dumps every register through stores and compares the data array with values it works out itself. A reset in the middle of a run shows that accumulated register state is cleared.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_JMP  = 6'h02;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_BNE  = 6'h05;
  localparam logic [5:0] OP_BLEZ = 6'h06;
  localparam logic [5:0] OP_BGTZ = 6'h07;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT
  } alu_op_e;

  typedef enum logic [2:0] {
    BR_NONE, BR_EQ, BR_NE, BR_LEZ, BR_GTZ
  } br_kind_e;

  typedef struct packed {
    logic     reg_we;
    logic     dst_rd;
    logic     use_imm;
    logic     load;
    logic     store;
    logic     jump;
    br_kind_e br;
    alu_op_e  alu;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [31:0] instr_i,
  output ctrl_t       ctrl_o
);
  logic [5:0] op, fn;
  logic       shamt_zero;

  assign op = instr_i[31:26];
  assign fn = instr_i[5:0];
  assign shamt_zero = (instr_i[10:6] == 5'd0);

  always_comb begin
    ctrl_o = '{reg_we: 1'b0, dst_rd: 1'b0, use_imm: 1'b0, load: 1'b0,
               store: 1'b0, jump: 1'b0, br: BR_NONE, alu: ALU_ADD};
    unique case (op)
      OP_REG: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.reg_we = shamt_zero;
        unique case (fn)
          FN_ADD:  ctrl_o.alu = ALU_ADD;
          FN_SUB:  ctrl_o.alu = ALU_SUB;
          FN_AND:  ctrl_o.alu = ALU_AND;
          FN_OR:   ctrl_o.alu = ALU_OR;
          FN_XOR:  ctrl_o.alu = ALU_XOR;
          FN_NOR:  ctrl_o.alu = ALU_NOR;
          FN_SLT:  ctrl_o.alu = ALU_SLT;
          default: ctrl_o.reg_we = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_LOAD: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.load    = 1'b1;
      end
      OP_STOR: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.store   = 1'b1;
      end
      OP_BEQ:  ctrl_o.br = BR_EQ;
      OP_BNE:  ctrl_o.br = BR_NE;
      OP_BLEZ: ctrl_o.br = BR_LEZ;
      OP_BGTZ: ctrl_o.br = BR_GTZ;
      OP_JMP:  ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_NOR: y_o = ~(a_i | b_i);
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ra_i,
  input  logic [IDX_W-1:0] rb_i,
  output logic [WIDTH-1:0] da_o,
  output logic [WIDTH-1:0] db_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wa_i,
  input  logic [WIDTH-1:0] wd_i
);
  logic [WIDTH-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  // index 0 is hard zero
  assign da_o = (ra_i == '0) ? '0 : regs_q[ra_i];
  assign db_o = (rb_i == '0) ? '0 : regs_q[rb_i];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int              NREGS    = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  localparam int             IDX_W    = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [XLEN-1:0] imem_data_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);
  logic [XLEN-1:0] pc_q, pc_d, pc_inc, br_tgt, jmp_tgt;
  logic [XLEN-1:0] imm_sx, rs_data, rt_data, alu_b, alu_y, wb_data;
  logic [IDX_W-1:0] rs_idx, rt_idx, rd_idx, wa;
  logic  taken;
  ctrl_t ctrl;

  assign rs_idx = imem_data_i[21 +: IDX_W];
  assign rt_idx = imem_data_i[16 +: IDX_W];
  assign rd_idx = imem_data_i[11 +: IDX_W];
  assign imm_sx = {{(XLEN-16){imem_data_i[15]}}, imem_data_i[15:0]};

  sc_decode u_dec (.instr_i(imem_data_i), .ctrl_o(ctrl));

  sc_regfile #(.NREGS(NREGS), .WIDTH(XLEN)) u_rf (
    .clk_i, .rst_ni,
    .ra_i(rs_idx), .rb_i(rt_idx),
    .da_o(rs_data), .db_o(rt_data),
    .we_i(ctrl.reg_we), .wa_i(wa), .wd_i(wb_data)
  );

  assign alu_b = ctrl.use_imm ? imm_sx : rt_data;

  sc_alu u_alu (.a_i(rs_data), .b_i(alu_b), .op_i(ctrl.alu), .y_o(alu_y));

  assign wa      = ctrl.dst_rd ? rd_idx : rt_idx;
  assign wb_data = ctrl.load ? dmem_rdata_i : alu_y;

  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_data;
  assign dmem_we_o    = ctrl.store & rst_ni;

  always_comb begin
    unique case (ctrl.br)
      BR_EQ:   taken = (rs_data == rt_data);
      BR_NE:   taken = (rs_data != rt_data);
      BR_LEZ:  taken = ($signed(rs_data) <= 0);
      BR_GTZ:  taken = ($signed(rs_data) > 0);
      default: taken = 1'b0;
    endcase
  end

  assign pc_inc  = pc_q + XLEN'(4);
  assign br_tgt  = pc_inc + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc_q[XLEN-1:28], imem_data_i[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)  pc_d = jmp_tgt;
    else if (taken) pc_d = br_tgt;
    else            pc_d = pc_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= pc_d;
  end

  assign imem_addr_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_core_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] instr_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] rt_val_i,
  input logic            we_i,
  input logic [XLEN-1:0] wdata_i
);
  logic [5:0]      op;
  logic [XLEN-1:0] br_off;
  logic            ctl_op;

  assign op     = instr_i[31:26];
  assign br_off = {{(XLEN-18){instr_i[15]}}, instr_i[15:0], 2'b00};
  assign ctl_op = (op == OP_JMP) || (op == OP_BEQ) || (op == OP_BNE) ||
                  (op == OP_BLEZ) || (op == OP_BGTZ);

  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_i == RESET_PC) && !we_i);

  a_r2_zero_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_STOR) && (instr_i[20:16] == 5'd0) |-> wdata_i == '0);

  a_r6_we_only_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_STOR) |-> !we_i);

  a_r7_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op == OP_BEQ) && (rs_val_i != rt_val_i)) ||
    ((op == OP_BNE) && (rs_val_i == rt_val_i))
    |=> pc_i == $past(pc_i) + XLEN'(4));

  a_r7_eq_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ) && (rs_val_i == rt_val_i)
    |=> pc_i == $past(pc_i) + XLEN'(4) + $past(br_off));

  a_r8_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_JMP)
    |=> pc_i == {$past(pc_i[XLEN-1:28]), $past(instr_i[25:0]), 2'b00});

  a_r10_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_op |=> pc_i == $past(pc_i) + XLEN'(4));
endmodule

bind sc_core sc_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pc_i     (imem_addr_o),
  .instr_i  (imem_data_i),
  .rs_val_i (rs_data),
  .rt_val_i (rt_data),
  .we_i     (dmem_we_o),
  .wdata_i  (dmem_wdata_o)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int checks = 0, fails = 0, store_cnt = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  sc_core dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata),
    .dmem_we_o(dmem_we), .dmem_rdata_i(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
      store_cnt <= store_cnt + 1;
    end
  end

  // {req, word index, expected value}
  localparam logic [71:0] EXP [16] = '{
    {8'd4,  32'd0,  32'h0000_0005},  // R4 positive imm
    {8'd4,  32'd1,  32'hFFFF_FFFD},  // R4 negative imm
    {8'd3,  32'd2,  32'h0000_0002},  // R3 add
    {8'd3,  32'd3,  32'h0000_0008},  // R3 sub
    {8'd3,  32'd4,  32'h0000_0005},  // R3 and
    {8'd3,  32'd5,  32'hFFFF_FFFD},  // R3 or
    {8'd3,  32'd6,  32'hFFFF_FFF8},  // R3 xor
    {8'd3,  32'd7,  32'h0000_0002},  // R3 nor
    {8'd3,  32'd8,  32'h0000_0001},  // R3 slt signed true
    {8'd3,  32'd9,  32'h0000_0000},  // R3 slt signed false
    {8'd2,  32'd10, 32'h0000_0000},  // R2 r0 stays zero
    {8'd7,  32'd11, 32'h0000_0005},  // R7 only correct paths ran
    {8'd7,  32'd12, 32'h0000_0000},  // R7 backward loop count
    {8'd5,  32'd17, 32'hFFFF_FFFD},  // R5 negative offset load
    {8'd5,  32'd18, 32'h0000_0004},  // R5 load then add
    {8'd9,  32'd19, 32'h0000_0005}   // R9 undefined ops no write
  };

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int idx);
    return {6'h02, 26'(idx)};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic load_prog();
    int p = 0;
    imem[p++] = enc_i(6'h08, 0, 1, 5);
    imem[p++] = enc_i(6'h08, 0, 2, -3);
    imem[p++] = enc_r(1, 2, 3, 6'h20);
    imem[p++] = enc_r(1, 2, 4, 6'h22);
    imem[p++] = enc_r(1, 2, 5, 6'h24);
    imem[p++] = enc_r(1, 2, 6, 6'h25);
    imem[p++] = enc_r(1, 2, 7, 6'h26);
    imem[p++] = enc_r(1, 2, 8, 6'h27);
    imem[p++] = enc_r(2, 1, 9, 6'h2A);
    imem[p++] = enc_r(1, 2, 10, 6'h2A);
    imem[p++] = enc_i(6'h08, 0, 0, 7);          // 10 write to r0
    imem[p++] = enc_i(6'h04, 1, 1, 1);          // 11 beq taken
    imem[p++] = enc_i(6'h08, 12, 12, 256);
    imem[p++] = enc_i(6'h08, 12, 12, 1);        // 13
    imem[p++] = enc_i(6'h05, 1, 1, 1);          // 14 bne not taken
    imem[p++] = enc_i(6'h08, 12, 12, 1);
    imem[p++] = enc_i(6'h06, 2, 0, 1);          // 16 blez neg taken
    imem[p++] = enc_i(6'h08, 12, 12, 256);
    imem[p++] = enc_i(6'h07, 2, 0, 1);          // 18 bgtz neg not taken
    imem[p++] = enc_i(6'h08, 12, 12, 1);
    imem[p++] = enc_i(6'h06, 1, 0, 1);          // 20 blez pos not taken
    imem[p++] = enc_i(6'h08, 12, 12, 1);
    imem[p++] = enc_i(6'h07, 1, 0, 1);          // 22 bgtz pos taken
    imem[p++] = enc_i(6'h08, 12, 12, 256);
    imem[p++] = enc_i(6'h06, 0, 0, 1);          // 24 blez zero taken
    imem[p++] = enc_i(6'h08, 12, 12, 256);
    imem[p++] = enc_i(6'h05, 1, 2, 1);          // 26 bne taken
    imem[p++] = enc_i(6'h08, 12, 12, 256);
    imem[p++] = enc_j(31);                      // 28
    imem[p++] = enc_i(6'h08, 12, 12, 256);
    imem[p++] = enc_i(6'h08, 12, 12, 256);
    imem[p++] = enc_i(6'h08, 12, 12, 1);        // 31
    imem[p++] = enc_i(6'h08, 0, 13, 2);
    imem[p++] = enc_i(6'h08, 13, 13, -1);       // 33
    imem[p++] = enc_i(6'h07, 13, 0, -2);        // 34 backward
    for (int r = 1; r <= 10; r++) imem[p++] = enc_i(6'h2B, 0, r, 4 * (r - 1));
    imem[p++] = enc_i(6'h2B, 0, 0, 40);
    imem[p++] = enc_i(6'h2B, 0, 12, 44);
    imem[p++] = enc_i(6'h2B, 0, 13, 48);
    imem[p++] = enc_i(6'h08, 0, 14, 64);        // 48
    imem[p++] = enc_i(6'h23, 14, 15, -60);
    imem[p++] = enc_i(6'h2B, 14, 15, 4);
    imem[p++] = enc_i(6'h23, 0, 16, 8);
    imem[p++] = enc_r(16, 16, 16, 6'h20);
    imem[p++] = enc_i(6'h2B, 0, 16, 72);        // 53
    imem[p++] = {6'h3F, 5'd0, 5'd1, 16'h1234};  // 54 undefined opcode
    imem[p++] = enc_r(0, 0, 1, 6'h01);          // 55 undefined funct
    imem[p++] = enc_i(6'h2B, 0, 1, 76);
    imem[p++] = enc_j(57);                      // 57 halt
  endtask

  task automatic clear_dmem();
    for (int i = 0; i < 64; i++) dmem[i] = 32'hDEAD_0000 | 32'(i);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
    load_prog();
    clear_dmem();
    repeat (2) @(negedge clk);
    check("R1 pc in reset", imem_addr, 32'h0);
    check("R1 we in reset", {31'd0, dmem_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 one step", imem_addr, 32'd4);
    repeat (11) @(negedge clk);
    check("R7 beq taken skips one", imem_addr, 32'd52);
    repeat (12) @(negedge clk);
    check("R8 jump target", imem_addr, 32'd124);
    repeat (60) @(negedge clk);
    check("R10 halted at jump", imem_addr, 32'd228);
    check("R6 store count", 32'(store_cnt), 32'd16);
    foreach (EXP[k]) begin
      checks++;
      if (dmem[EXP[k][37:32]] !== EXP[k][31:0]) begin
        fails++;
        $display("FAIL R%0d word %0d got=%08h exp=%08h", EXP[k][71:64],
                 EXP[k][63:32], dmem[EXP[k][37:32]], EXP[k][31:0]);
      end
    end
    // R1: reset mid-run clears registers (r12 accumulates from itself)
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 pc after reset", imem_addr, 32'h0);
    clear_dmem();
    rst_n = 1'b1;
    repeat (90) @(negedge clk);
    check("R1 r12 restarted from zero", dmem[11], 32'd5);
    check("R2 r0 store after rerun", dmem[10], 32'd0);
    check("R9 undefined leaves r1", dmem[19], 32'd5);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20ns * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule